// File: doc/BRIEF.md
# Tournament Direction Chooser

This block merges two conditional-branch direction guesses into one. One guess comes from a per-address bimodal table that the block holds itself. The other comes from an external global-history predictor and enters on a port. A second table of 2-bit saturating counters, the chooser table, records which of the two sources has recently done better for each address slot. At fetch the block reads both tables at an index cut from the branch address. It reports the bimodal guess and the chooser's verdict, and forwards the guess of the source the verdict favours.

At execute the pipeline returns the resolved branch: its address, the two component guesses made for it at fetch, and the real outcome. The bimodal counter at that slot moves toward the outcome. The chooser counter moves only when exactly one of the two components was right, and it moves toward that component. The table depth, the address bits skipped for instruction alignment, and the initial leaning of the chooser are all parameters.

Top module: `tournament_chooser`

## Requirements
- R1: The table index is address bits [IP_SHIFT +: IDX_W]. Fetch and execute use the same slice, and both tables share that index.
- R2: On an execute update, the bimodal counter at the index goes up by one when exe_taken is 1, saturating at 3. It goes down by one when exe_taken is 0, saturating at 0.
- R3: fch_bim_pred is the top bit of the bimodal counter at the fetch index. Every bimodal counter resets to 2 (weakly taken).
- R4: On an execute update where exe_bim_pred equals exe_taken and exe_glob_pred does not, the chooser counter goes up by one, saturating at 3.
- R5: On an execute update where exe_glob_pred equals exe_taken and exe_bim_pred does not, the chooser counter goes down by one, saturating at 0.
- R6: On an execute update where both component guesses were right, or both were wrong, the chooser counter keeps its value.
- R7: fch_use_bim is the top bit of the chooser counter at the fetch index. fch_pred equals fch_bim_pred when fch_use_bim is 1, and fch_glob_pred when it is 0.
- R8: Every chooser counter resets to 2 when CHS_INIT_BIM is 1, and to 1 when it is 0.
- R9: Fetch outputs are combinational from the tables. A fetch and an update at the same index in the same cycle see the value from before the update, and the new value is visible from the next cycle.
- R10: While exe_valid is 0, neither table changes, whatever the other execute inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fch_addr | input | ADDR_W | Address of the branch being predicted |
| fch_glob_pred | input | 1 | Global-history component guess for the fetched branch |
| fch_pred | output | 1 | Final direction guess, 1 means taken |
| fch_bim_pred | output | 1 | Bimodal component guess at the fetch index |
| fch_use_bim | output | 1 | 1 when the chooser favours the bimodal source |
| exe_valid | input | 1 | A resolved branch is presented this cycle |
| exe_addr | input | ADDR_W | Address of the resolved branch |
| exe_bim_pred | input | 1 | Bimodal guess that was made for it at fetch |
| exe_glob_pred | input | 1 | Global guess that was made for it at fetch |
| exe_taken | input | 1 | Actual outcome, 1 means taken |

## Verification
The checker assumes that every input is 0 or 1, never X, from reset release onward. It also assumes that one update port is the only writer, so a slot read in two consecutive cycles can differ only by the step that the previous cycle's update implies. The component guesses on the execute side are not assumed to match what the tables held. The stimulus therefore drives them freely and independently, including combinations that a real pipeline would never present. It never leaves a port undriven.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

   typedef logic [1:0] ctr2_t;

   localparam ctr2_t CTR_LOW_HARD  = 2'b00;
   localparam ctr2_t CTR_LOW_SOFT  = 2'b01;
   localparam ctr2_t CTR_HIGH_SOFT = 2'b10;
   localparam ctr2_t CTR_HIGH_HARD = 2'b11;

   typedef enum logic [1:0] {
      STEP_HOLD = 2'b00,
      STEP_UP   = 2'b01,
      STEP_DOWN = 2'b10
   } step_e;

   function automatic ctr2_t ctr_step(input ctr2_t c, input step_e s);
      ctr2_t r;
      r = c;
      case (s)
         STEP_UP:   if (c != CTR_HIGH_HARD) r = c + 2'd1;
         STEP_DOWN: if (c != CTR_LOW_HARD)  r = c - 2'd1;
         default:   r = c;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/tsel_ctr_array.sv
module tsel_ctr_array
   import tsel_pkg::*;
#(
   parameter int    IDX_W    = 8,
   parameter ctr2_t INIT_VAL = CTR_HIGH_SOFT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output ctr2_t            rd_ctr,
   input  logic             upd_en,
   input  logic [IDX_W-1:0] upd_idx,
   input  step_e            upd_step
);

   localparam int DEPTH = 1 << IDX_W;

   ctr2_t slot_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic hit;
      assign hit = upd_en && (upd_idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   slot_q[g] <= INIT_VAL;
         else if (hit) slot_q[g] <= ctr_step(slot_q[g], upd_step);
      end
   end

   assign rd_ctr = slot_q[rd_idx];

endmodule

// File: rtl/tsel_judge.sv
module tsel_judge
   import tsel_pkg::*;
(
   input  logic  bim_pred,
   input  logic  glob_pred,
   input  logic  taken,
   output step_e bim_step,
   output step_e chs_step
);

   logic bim_ok;
   logic glob_ok;

   assign bim_ok  = (bim_pred  == taken);
   assign glob_ok = (glob_pred == taken);

   always_comb begin
      bim_step = taken ? STEP_UP : STEP_DOWN;
      unique case ({bim_ok, glob_ok})
         2'b10:   chs_step = STEP_UP;
         2'b01:   chs_step = STEP_DOWN;
         default: chs_step = STEP_HOLD;
      endcase
   end

endmodule

// File: rtl/tournament_chooser.sv
module tournament_chooser
   import tsel_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int IDX_W        = 8,
   parameter int IP_SHIFT     = 2,
   parameter bit CHS_INIT_BIM = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] fch_addr,
   input  logic              fch_glob_pred,
   output logic              fch_pred,
   output logic              fch_bim_pred,
   output logic              fch_use_bim,
   input  logic              exe_valid,
   input  logic [ADDR_W-1:0] exe_addr,
   input  logic              exe_bim_pred,
   input  logic              exe_glob_pred,
   input  logic              exe_taken
);

   localparam ctr2_t BIM_INIT = CTR_HIGH_SOFT;
   localparam ctr2_t CHS_INIT = CHS_INIT_BIM ? CTR_HIGH_SOFT : CTR_LOW_SOFT;

   if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
      $error("tournament_chooser: IDX_W must lie in 1..12");
   end
   if (IP_SHIFT < 0 || IP_SHIFT + IDX_W > ADDR_W) begin : g_bad_slice
      $error("tournament_chooser: IP_SHIFT + IDX_W exceeds ADDR_W");
   end

   logic [IDX_W-1:0] fch_idx;
   logic [IDX_W-1:0] exe_idx;
   ctr2_t            bim_rd;
   ctr2_t            chs_rd;
   step_e            bim_step;
   step_e            chs_step;

   assign fch_idx = fch_addr[IP_SHIFT +: IDX_W];
   assign exe_idx = exe_addr[IP_SHIFT +: IDX_W];

   tsel_judge u_judge (
      .bim_pred  (exe_bim_pred),
      .glob_pred (exe_glob_pred),
      .taken     (exe_taken),
      .bim_step  (bim_step),
      .chs_step  (chs_step)
   );

   tsel_ctr_array #(
      .IDX_W    (IDX_W),
      .INIT_VAL (BIM_INIT)
   ) u_bim_tab (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (fch_idx),
      .rd_ctr   (bim_rd),
      .upd_en   (exe_valid),
      .upd_idx  (exe_idx),
      .upd_step (bim_step)
   );

   tsel_ctr_array #(
      .IDX_W    (IDX_W),
      .INIT_VAL (CHS_INIT)
   ) u_chs_tab (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (fch_idx),
      .rd_ctr   (chs_rd),
      .upd_en   (exe_valid && (chs_step != STEP_HOLD)),
      .upd_idx  (exe_idx),
      .upd_step (chs_step)
   );

   assign fch_bim_pred = bim_rd[1];
   assign fch_use_bim  = chs_rd[1];
   assign fch_pred     = fch_use_bim ? fch_bim_pred : fch_glob_pred;

endmodule

// File: rtl/tsel_chk.sv
module tsel_chk #(
   parameter int IDX_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [IDX_W-1:0] fch_idx,
   input logic [IDX_W-1:0] exe_idx,
   input logic             exe_valid,
   input logic             exe_bim_pred,
   input logic             exe_glob_pred,
   input logic             exe_taken,
   input logic [1:0]       bim_rd,
   input logic [1:0]       chs_rd,
   input logic             fch_glob_pred,
   input logic             fch_bim_pred,
   input logic             fch_use_bim,
   input logic             fch_pred
);

   function automatic logic [1:0] up2(input logic [1:0] c);
      return (c == 2'b11) ? c : c + 2'd1;
   endfunction
   function automatic logic [1:0] dn2(input logic [1:0] c);
      return (c == 2'b00) ? c : c - 2'd1;
   endfunction

   logic same_slot;
   logic b_ok;
   logic g_ok;
   assign same_slot = exe_valid && (fch_idx == exe_idx);
   assign b_ok      = (exe_bim_pred == exe_taken);
   assign g_ok      = (exe_glob_pred == exe_taken);

   // R2
   bim_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(same_slot && exe_taken) && fch_idx == $past(fch_idx)
      |-> bim_rd == up2($past(bim_rd)));

   // R2
   bim_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(same_slot && !exe_taken) && fch_idx == $past(fch_idx)
      |-> bim_rd == dn2($past(bim_rd)));

   // R4
   chs_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(same_slot && b_ok && !g_ok) && fch_idx == $past(fch_idx)
      |-> chs_rd == up2($past(chs_rd)));

   // R5
   chs_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(same_slot && !b_ok && g_ok) && fch_idx == $past(fch_idx)
      |-> chs_rd == dn2($past(chs_rd)));

   // R6
   chs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(same_slot && (b_ok == g_ok)) && fch_idx == $past(fch_idx)
      |-> $stable(chs_rd));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!exe_valid) && fch_idx == $past(fch_idx)
      |-> $stable(bim_rd) && $stable(chs_rd));

   // R7
   pick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fch_pred == (fch_use_bim ? fch_bim_pred : fch_glob_pred));

   // R3
   bim_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fch_bim_pred == bim_rd[1] && fch_use_bim == chs_rd[1]);

endmodule

bind tournament_chooser tsel_chk #(.IDX_W(IDX_W)) u_tsel_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .fch_idx       (fch_idx),
   .exe_idx       (exe_idx),
   .exe_valid     (exe_valid),
   .exe_bim_pred  (exe_bim_pred),
   .exe_glob_pred (exe_glob_pred),
   .exe_taken     (exe_taken),
   .bim_rd        (bim_rd),
   .chs_rd        (chs_rd),
   .fch_glob_pred (fch_glob_pred),
   .fch_bim_pred  (fch_bim_pred),
   .fch_use_bim   (fch_use_bim),
   .fch_pred      (fch_pred)
);

// File: tb/tournament_chooser_bench.sv
module tournament_chooser_bench;

   localparam int AW    = 16;
   localparam int IW    = 4;
   localparam int SH    = 2;
   localparam int DEPTH = 1 << IW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] fch_addr = '0;
   logic          fch_glob_pred = 1'b0;
   logic          fch_pred, fch_bim_pred, fch_use_bim;
   logic          exe_valid = 1'b0;
   logic [AW-1:0] exe_addr = '0;
   logic          exe_bim_pred = 1'b0;
   logic          exe_glob_pred = 1'b0;
   logic          exe_taken = 1'b0;

   int checks = 0;
   int fails  = 0;
   int m_bim [DEPTH];
   int m_chs [DEPTH];
   string tag = "R3 R8";

   always #2 clk = ~clk;

   tournament_chooser #(
      .ADDR_W(AW), .IDX_W(IW), .IP_SHIFT(SH), .CHS_INIT_BIM(1'b1)
   ) u_tournament_chooser (
      .clk(clk), .rst_n(rst_n),
      .fch_addr(fch_addr), .fch_glob_pred(fch_glob_pred),
      .fch_pred(fch_pred), .fch_bim_pred(fch_bim_pred), .fch_use_bim(fch_use_bim),
      .exe_valid(exe_valid), .exe_addr(exe_addr), .exe_bim_pred(exe_bim_pred),
      .exe_glob_pred(exe_glob_pred), .exe_taken(exe_taken)
   );

   function automatic int slot(input logic [AW-1:0] a);
      return (int'(a) >> SH) % DEPTH;
   endfunction

   task automatic cmp(input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0b expected %0b (t=%0t)", tag, what, act, exp, $time);
      end
   endtask

   // one cycle: drive after falling edge, compare mid-phase, then advance model
   task automatic cyc(input logic [AW-1:0] fa, input logic fg,
                      input logic ev, input logic [AW-1:0] ea,
                      input logic eb, input logic eg, input logic et);
      int  fi, ei;
      logic xb, xu;
      @(negedge clk);
      fch_addr = fa; fch_glob_pred = fg;
      exe_valid = ev; exe_addr = ea; exe_bim_pred = eb;
      exe_glob_pred = eg; exe_taken = et;
      #1;
      fi = slot(fa);
      xb = (m_bim[fi] >= 2);
      xu = (m_chs[fi] >= 2);
      cmp("bimodal guess", fch_bim_pred, xb);
      cmp("chooser verdict", fch_use_bim, xu);
      cmp("final guess", fch_pred, xu ? xb : fg);
      if (ev) begin
         ei = slot(ea);
         if (et) m_bim[ei] = (m_bim[ei] < 3) ? m_bim[ei] + 1 : 3;
         else    m_bim[ei] = (m_bim[ei] > 0) ? m_bim[ei] - 1 : 0;
         if ((eb == et) && (eg != et))      m_chs[ei] = (m_chs[ei] < 3) ? m_chs[ei] + 1 : 3;
         else if ((eb != et) && (eg == et)) m_chs[ei] = (m_chs[ei] > 0) ? m_chs[ei] - 1 : 0;
      end
   endtask

   function automatic logic [AW-1:0] at(input int s);
      return AW'((($urandom_range(0, 255)) << (SH + IW)) | (s << SH) | $urandom_range(0, 3));
   endfunction

   initial begin
      for (int i = 0; i < DEPTH; i++) begin m_bim[i] = 2; m_chs[i] = 2; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R3 R8: reset state of every slot, both global guesses
      tag = "R3 R8";
      for (int s = 0; s < DEPTH; s++) cyc(at(s), s[0], 1'b0, '0, 1'b0, 1'b0, 1'b0);

      // R4: bimodal right, global wrong, past saturation
      tag = "R4";
      for (int k = 0; k < 4; k++) cyc(at(5), 1'b0, 1'b1, at(5), 1'b1, 1'b0, 1'b1);
      cyc(at(5), 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0);

      // R5: global right, bimodal wrong, down to the floor; R7 then follows global
      tag = "R5 R7";
      for (int k = 0; k < 5; k++) cyc(at(6), 1'b1, 1'b1, at(6), 1'b1, 1'b0, 1'b0);
      cyc(at(6), 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0);
      cyc(at(6), 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0);

      // R6: both right, then both wrong; chooser keeps its leaning
      tag = "R6";
      for (int k = 0; k < 3; k++) cyc(at(7), 1'b0, 1'b1, at(7), 1'b1, 1'b1, 1'b1);
      for (int k = 0; k < 3; k++) cyc(at(7), 1'b0, 1'b1, at(7), 1'b0, 1'b0, 1'b1);
      cyc(at(7), 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0);

      // R2: bimodal counter saturates low, then one taken leaves it not-taken
      tag = "R2";
      for (int k = 0; k < 4; k++) cyc(at(8), 1'b1, 1'b1, at(8), 1'b0, 1'b0, 1'b0);
      cyc(at(8), 1'b1, 1'b1, at(8), 1'b0, 1'b0, 1'b1);
      cyc(at(8), 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0);

      // R10: garbage on execute side with exe_valid low
      tag = "R10";
      for (int k = 0; k < 6; k++)
         cyc(at(9), k[0], 1'b0, at(9), k[1], k[2], k[0]);

      // R9: fetch and update on one slot in one cycle, then the cycle after
      tag = "R9";
      cyc(at(10), 1'b0, 1'b1, at(10), 1'b0, 1'b0, 1'b0);
      cyc(at(10), 1'b0, 1'b1, at(10), 1'b0, 1'b0, 1'b0);
      cyc(at(10), 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0);

      // R1 R2 R7: mixed random traffic over a few slots with varied high bits
      tag = "R1 R2 R7";
      for (int k = 0; k < 3000; k++)
         cyc(at($urandom_range(0, DEPTH - 1)), 1'($urandom),
             1'($urandom_range(0, 3) != 0), at($urandom_range(0, DEPTH - 1)),
             1'($urandom), 1'($urandom), 1'($urandom));

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(4 * 150000);
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule